// File: doc/BRIEF.md
# Minimal 8-bit Accumulator Processor Core

This block is a small multi-cycle processor with an 8-bit accumulator, one 8-bit index register, an 8-bit stack pointer and a 16-bit program counter. It talks to a synchronous memory over a single bus. The address, write data and write strobe are driven from the core, and read data comes back one clock after the address was presented. Carry and zero are the only status flags.

The instruction set is sparse by intent. NOR is the only logic operation. Addition and subtraction take no carry in. Branches exist only for a flag that is set. The index register can be stepped up or down but cannot be compared. Operands are either an immediate byte, an absolute address, or an absolute address offset by the index register. Subroutines use a downward stack held in one fixed 256-byte page.

A host embeds the core next to a RAM with a one-cycle read latency, places a program and a little-endian start address at the reset vector, and releases reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, the core writes nothing and addresses the reset vector (default 0xFFFC). After release it loads the PC from the vector (low byte at the vector, high byte at vector+1), starts execution there, and clears both flags. SP starts at 0xFF.
- R2: Each opcode is one byte. For the grouped operations, opcode bits [1:0] select the mode: 00 immediate (one operand byte), 01 absolute (two-byte little-endian address), 10 absolute plus X (address plus zero-extended X, 16-bit sum). Jumps, branches and call always carry a two-byte absolute target.
- R3: LDA (0x10/0x11/0x12) and LDX (0x18/0x19/0x1A) load the register and set Z when the loaded value is zero. C is unchanged.
- R4: STA (0x15/0x16) and STX (0x1D/0x1E) write the register to memory and leave C and Z unchanged.
- R5: ADD (0x20/0x21/0x22) sets A to A+M with no carry in. C becomes the carry out and Z is set when the result is zero.
- R6: SUB (0x24/0x25/0x26) sets A to A-M with C=1 when no borrow occurs (A>=M) and Z set on a zero result. CMP (0x28/0x29/0x2A) sets the same flags and leaves A unchanged.
- R7: NOR (0x2C/0x2D/0x2E) sets A to the bitwise NOR of A and M and updates Z. C is unchanged.
- R8: INX (0x34) and DEX (0x35) step X by one, modulo 256. They update Z and leave C unchanged.
- R9: PHA (0x30) and PHX (0x32) write the register to address 0x01:SP, then decrement SP. Flags are unchanged.
- R10: PLA (0x31) and PLX (0x33) increment SP, then load the register from 0x01:SP. Z is set from the pulled value and C is unchanged.
- R11: JMP (0x40) loads the target. BCS (0x41) and BZ (0x42) load the target only when C or Z respectively is set, and otherwise continue with the next instruction.
- R12: JSR (0x43) pushes the address of the following instruction, high byte first and then low byte, and jumps to the target. RTS (0x44) pulls the low byte and then the high byte and resumes at that address.
- R13: Any opcode not listed is a one-byte no-operation that changes no register, flag or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | 16 | Memory address for the current bus cycle |
| mem_rdata | input | 8 | Read data, valid one clock after the address was presented |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe; memory stores mem_wdata at mem_addr on the clock edge |

## Verification
The bench builds the core with its default parameters: an 8-bit data path, a 16-bit address, the reset vector at 0xFFFC, the stack in page 0x01 and a two-stage reset synchronizer. Its 4 KiB memory aliases the upper address bits. That still places the vector, the stack page, the program at 0x0200 and the result area at 0x0300 in separate places. With these values, one small program template can check every arithmetic flag outcome, including carry out, the no-borrow carry and zero results. A second program pushes the stack pointer through call, return and mixed pushes and pulls, checks index wrap from 0xFF to 0x00, and checks taken and untaken branches.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    ST_RST0, ST_RST1, ST_RST2, ST_FETCH, ST_DEC, ST_IMM, ST_LO, ST_HI,
    ST_MEM, ST_PUSHLO, ST_PULLA, ST_PULLD, ST_RLO, ST_RHI
  } state_t;

  typedef enum logic [3:0] {
    K_NOP, K_LOAD, K_STORE, K_ALU, K_PUSH, K_PULL, K_INX, K_DEX,
    K_JMP, K_BCS, K_BZ, K_JSR, K_RTS
  } kind_t;

  typedef enum logic [1:0] {M_IMP, M_IMM, M_ABS, M_ABX} mode_t;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_NOR, ALU_INC, ALU_DEC
  } alu_op_t;

  typedef struct packed {
    kind_t   kind;
    mode_t   mode;
    logic    use_x;
    alu_op_t alu;
    logic    wb;
  } dec_t;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  mode_t grp_mode;
  logic  grp_ok;
  logic  mem_ok;

  always_comb begin
    case (opcode[1:0])
      2'b00:   grp_mode = M_IMM;
      2'b01:   grp_mode = M_ABS;
      2'b10:   grp_mode = M_ABX;
      default: grp_mode = M_IMP;
    endcase
    grp_ok = (opcode[1:0] != 2'b11);
    mem_ok = (opcode[1:0] == 2'b01) || (opcode[1:0] == 2'b10);
  end

  always_comb begin
    dec.kind  = K_NOP;
    dec.mode  = M_IMP;
    dec.use_x = 1'b0;
    dec.alu   = ALU_PASS;
    dec.wb    = 1'b0;
    case (opcode[7:2])
      6'h04, 6'h06: if (grp_ok) begin
        dec.kind  = K_LOAD;
        dec.mode  = grp_mode;
        dec.use_x = opcode[3];
        dec.wb    = 1'b1;
      end
      6'h05, 6'h07: if (mem_ok) begin
        dec.kind  = K_STORE;
        dec.mode  = grp_mode;
        dec.use_x = opcode[3];
      end
      6'h08, 6'h09, 6'h0A, 6'h0B: if (grp_ok) begin
        dec.kind = K_ALU;
        dec.mode = grp_mode;
        dec.wb   = (opcode[3:2] != 2'b10);
        case (opcode[3:2])
          2'b00:   dec.alu = ALU_ADD;
          2'b11:   dec.alu = ALU_NOR;
          default: dec.alu = ALU_SUB;
        endcase
      end
      6'h0C: begin
        dec.kind  = opcode[0] ? K_PULL : K_PUSH;
        dec.use_x = opcode[1];
      end
      6'h0D: if (!opcode[1]) begin
        dec.kind  = opcode[0] ? K_DEX : K_INX;
        dec.use_x = 1'b1;
        dec.alu   = opcode[0] ? ALU_DEC : ALU_INC;
      end
      6'h10: begin
        dec.mode = M_ABS;
        case (opcode[1:0])
          2'b00:   dec.kind = K_JMP;
          2'b01:   dec.kind = K_BCS;
          2'b10:   dec.kind = K_BZ;
          default: dec.kind = K_JSR;
        endcase
      end
      6'h11: if (opcode[1:0] == 2'b00) dec.kind = K_RTS;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_t       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          co,
  output logic          zero
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW:0] sum;
  logic [DW:0] diff;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    diff = {1'b0, a} - {1'b0, b};
    co   = 1'b0;
    case (op)
      ALU_ADD: begin y = sum[DW-1:0];  co = sum[DW];   end
      ALU_SUB: begin y = diff[DW-1:0]; co = ~diff[DW]; end
      ALU_NOR: y = ~(a | b);
      ALU_INC: y = a + ONE;
      ALU_DEC: y = a - ONE;
      default: y = b;
    endcase
    zero = (y == '0);
  end

  always_comb begin
    if (op == ALU_SUB) begin
      AST_SUB_NOBORROW: assert (co == (a >= b)) else $error("sub carry mismatch"); // R6
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [15:0] RESET_VEC   = 16'hFFFC,
  parameter logic [7:0]  STACK_PAGE  = 8'h01,
  parameter int          SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we
);

  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [DW-1:0] ONE_D = DW'(1);

  logic rst_sn;

  state_t        state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, tmp_q, tmp_d;
  logic [DW-1:0] sp_q, sp_d, a_q, a_d, x_q, x_d, ir_q, ir_d, lo_q, lo_d;
  logic          c_q, c_d, z_q, z_d;

  dec_t          dec;
  logic [DW-1:0] dec_src;
  logic [DW-1:0] alu_a, alu_y;
  logic          alu_co, alu_zero;
  logic [AW-1:0] target, ea;
  logic [AW-1:0] stack_addr;
  logic [DW-1:0] reg_sel;

  acc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign dec_src = (state_q == ST_DEC) ? mem_rdata : ir_q;

  acc_decode u_dec (
    .opcode (dec_src),
    .dec    (dec)
  );

  assign alu_a = dec.use_x ? x_q : a_q;

  acc_alu #(.DW(DW)) u_alu (
    .op   (dec.alu),
    .a    (alu_a),
    .b    (mem_rdata),
    .y    (alu_y),
    .co   (alu_co),
    .zero (alu_zero)
  );

  assign target     = {mem_rdata, lo_q};
  assign ea         = target + ((dec.mode == M_ABX) ? {{DW{1'b0}}, x_q} : '0);
  assign stack_addr = {STACK_PAGE, sp_q};
  assign reg_sel    = dec.use_x ? x_q : a_q;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    sp_d      = sp_q;
    a_d       = a_q;
    x_d       = x_q;
    c_d       = c_q;
    z_d       = z_q;
    ir_d      = ir_q;
    lo_d      = lo_q;
    tmp_d     = tmp_q;
    mem_addr  = pc_q;
    mem_wdata = reg_sel;
    mem_we    = 1'b0;

    case (state_q)
      ST_RST0: begin
        mem_addr = RESET_VEC;
        state_d  = ST_RST1;
      end
      ST_RST1: begin
        lo_d     = mem_rdata;
        mem_addr = RESET_VEC + ONE_A;
        state_d  = ST_RST2;
      end
      ST_RST2: begin
        pc_d    = target;
        state_d = ST_FETCH;
      end
      ST_FETCH: begin
        pc_d    = pc_q + ONE_A;
        state_d = ST_DEC;
      end
      ST_DEC: begin
        ir_d = mem_rdata;
        case (dec.kind)
          K_NOP: state_d = ST_FETCH;
          K_INX, K_DEX: begin
            x_d     = alu_y;
            z_d     = alu_zero;
            state_d = ST_FETCH;
          end
          K_PUSH: begin
            mem_we   = 1'b1;
            mem_addr = stack_addr;
            sp_d     = sp_q - ONE_D;
            state_d  = ST_FETCH;
          end
          K_PULL, K_RTS: begin
            sp_d    = sp_q + ONE_D;
            state_d = ST_PULLA;
          end
          default: begin
            pc_d    = pc_q + ONE_A;
            state_d = (dec.mode == M_IMM) ? ST_IMM : ST_LO;
          end
        endcase
      end
      ST_LO: begin
        lo_d    = mem_rdata;
        pc_d    = pc_q + ONE_A;
        state_d = ST_HI;
      end
      ST_HI: begin
        state_d = ST_FETCH;
        case (dec.kind)
          K_STORE: begin
            mem_we   = 1'b1;
            mem_addr = ea;
          end
          K_LOAD, K_ALU: begin
            mem_addr = ea;
            state_d  = ST_MEM;
          end
          K_JMP: pc_d = target;
          K_BCS: if (c_q) pc_d = target;
          K_BZ:  if (z_q) pc_d = target;
          K_JSR: begin
            tmp_d     = target;
            mem_we    = 1'b1;
            mem_addr  = stack_addr;
            mem_wdata = pc_q[AW-1:DW];
            sp_d      = sp_q - ONE_D;
            state_d   = ST_PUSHLO;
          end
          default: ;
        endcase
      end
      ST_PUSHLO: begin
        mem_we    = 1'b1;
        mem_addr  = stack_addr;
        mem_wdata = pc_q[DW-1:0];
        sp_d      = sp_q - ONE_D;
        pc_d      = tmp_q;
        state_d   = ST_FETCH;
      end
      ST_IMM, ST_MEM: begin
        state_d = ST_FETCH;
        if (dec.kind == K_LOAD) begin
          if (dec.use_x) x_d = mem_rdata;
          else           a_d = mem_rdata;
          z_d = (mem_rdata == '0);
        end else if (dec.kind == K_ALU) begin
          if (dec.wb) a_d = alu_y;
          z_d = alu_zero;
          if (dec.alu != ALU_NOR) c_d = alu_co;
        end
      end
      ST_PULLA: begin
        mem_addr = stack_addr;
        if (dec.kind == K_RTS) begin
          sp_d    = sp_q + ONE_D;
          state_d = ST_RLO;
        end else begin
          state_d = ST_PULLD;
        end
      end
      ST_PULLD: begin
        if (dec.use_x) x_d = mem_rdata;
        else           a_d = mem_rdata;
        z_d     = (mem_rdata == '0);
        state_d = ST_FETCH;
      end
      ST_RLO: begin
        lo_d     = mem_rdata;
        mem_addr = stack_addr;
        state_d  = ST_RHI;
      end
      ST_RHI: begin
        pc_d    = target;
        state_d = ST_FETCH;
      end
      default: state_d = ST_RST0;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_RST0;
      pc_q    <= '0;
      sp_q    <= '1;
      a_q     <= '0;
      x_q     <= '0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      ir_q    <= '0;
      lo_q    <= '0;
      tmp_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      sp_q    <= sp_d;
      a_q     <= a_d;
      x_q     <= x_d;
      c_q     <= c_d;
      z_q     <= z_d;
      ir_q    <= ir_d;
      lo_q    <= lo_d;
      tmp_q   <= tmp_d;
    end
  end

  AST_RST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_RST0 || state_q == ST_RST1 || state_q == ST_RST2) |-> !mem_we); // R1

  AST_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we |=> ($stable(c_q) && $stable(z_q))); // R4

  AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_DEC && dec.kind == K_PUSH) |=> (sp_q == $past(sp_q) - ONE_D)); // R9

  AST_PULL_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_PULLD) |=> (z_q == ($past(mem_rdata) == '0))); // R10

  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_HI && dec.kind == K_BCS && !c_q) |=> (pc_q == $past(pc_q))); // R11

  AST_NOR_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_sn)
    ((state_q == ST_IMM || state_q == ST_MEM) && dec.alu == ALU_NOR) |=> $stable(c_q)); // R7

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;

  logic [7:0]  mem [4096];
  logic        ld_en;
  logic [11:0] ld_addr;
  logic [7:0]  ld_data;

  int checks;
  int failures;

  acc_cpu u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (ld_en)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  // op, operand, initial A, expected A, flags {cin, expC, expZ, 0}
  localparam logic [35:0] VECS [13] = '{
    36'h20_34_12_46_8, 36'h20_20_F0_10_4, 36'h20_80_80_00_6,
    36'h24_20_50_30_4, 36'h24_50_20_D0_8, 36'h24_33_33_00_6,
    36'h28_41_40_40_8, 36'h28_40_40_40_6,
    36'h2C_F0_0F_00_E, 36'h2C_00_00_FF_0, 36'h2C_7F_81_00_2,
    36'h10_00_55_00_E, 36'hFF_00_77_77_C
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic prep();
    rst_n = 1'b0;
    #1;
    for (int i = 12'h300; i < 12'h340; i++) poke(12'(i), 8'h00);
    for (int i = 12'h1F0; i < 12'h200; i++) poke(12'(i), 8'h00);
    poke(12'hFFC, 8'h00);
    poke(12'hFFD, 8'h02);
  endtask

  task automatic run();
    rst_n = 1'b1;
    repeat (400) @(posedge clk);
    #1;
  endtask

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h20:        return "R5";
      8'h24, 8'h28: return "R6";
      8'h2C:        return "R7";
      8'h10:        return "R3";
      default:      return "R13";
    endcase
  endfunction

  initial begin
    checks = 0; failures = 0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state at the ports
    check("R1 reset addr", mem_addr, 16'hFFFC);
    check("R1 reset we", {15'd0, mem_we}, 16'd0);

    // table walk: ALU, load and undefined-opcode cases
    for (int v = 0; v < 13; v++) begin
      logic [7:0] op, opr, ai, ea;
      logic [3:0] fl;
      {op, opr, ai, ea, fl} = VECS[v];
      prep();
      poke(12'h200, 8'h10); poke(12'h201, 8'h00);
      poke(12'h202, fl[3] ? 8'h24 : 8'h20); poke(12'h203, 8'h00);
      poke(12'h204, 8'h10); poke(12'h205, ai);
      poke(12'h206, op);    poke(12'h207, opr);
      poke(12'h208, 8'h15); poke(12'h209, 8'h00); poke(12'h20A, 8'h03);
      poke(12'h20B, 8'h42); poke(12'h20C, 8'h13); poke(12'h20D, 8'h02);
      poke(12'h20E, 8'h18); poke(12'h20F, 8'h00);
      poke(12'h210, 8'h40); poke(12'h211, 8'h15); poke(12'h212, 8'h02);
      poke(12'h213, 8'h18); poke(12'h214, 8'h01);
      poke(12'h215, 8'h1D); poke(12'h216, 8'h01); poke(12'h217, 8'h03);
      poke(12'h218, 8'h41); poke(12'h219, 8'h20); poke(12'h21A, 8'h02);
      poke(12'h21B, 8'h18); poke(12'h21C, 8'h00);
      poke(12'h21D, 8'h40); poke(12'h21E, 8'h22); poke(12'h21F, 8'h02);
      poke(12'h220, 8'h18); poke(12'h221, 8'h01);
      poke(12'h222, 8'h1D); poke(12'h223, 8'h02); poke(12'h224, 8'h03);
      poke(12'h225, 8'h40); poke(12'h226, 8'h25); poke(12'h227, 8'h02);
      run();
      check({tag_of(op), " A"}, {8'h00, mem[12'h300]}, {8'h00, ea});
      check({tag_of(op), " Z"}, {8'h00, mem[12'h301]}, {15'd0, fl[1]});
      check({tag_of(op), " C"}, {8'h00, mem[12'h302]}, {15'd0, fl[2]});
    end

    // directed: indexing, stack, call/return, branches, X wrap
    prep();
    poke(12'h200, 8'h18); poke(12'h201, 8'h02);
    poke(12'h202, 8'h10); poke(12'h203, 8'hA5);
    poke(12'h204, 8'h16); poke(12'h205, 8'h00); poke(12'h206, 8'h03);
    poke(12'h207, 8'h35);
    poke(12'h208, 8'h12); poke(12'h209, 8'h01); poke(12'h20A, 8'h03);
    poke(12'h20B, 8'h15); poke(12'h20C, 8'h10); poke(12'h20D, 8'h03);
    poke(12'h20E, 8'h30);
    poke(12'h20F, 8'h32);
    poke(12'h210, 8'h43); poke(12'h211, 8'h40); poke(12'h212, 8'h02);
    poke(12'h213, 8'h31);
    poke(12'h214, 8'h15); poke(12'h215, 8'h11); poke(12'h216, 8'h03);
    poke(12'h217, 8'h33);
    poke(12'h218, 8'h1D); poke(12'h219, 8'h12); poke(12'h21A, 8'h03);
    poke(12'h21B, 8'h10); poke(12'h21C, 8'h00);
    poke(12'h21D, 8'h30);
    poke(12'h21E, 8'h10); poke(12'h21F, 8'h07);
    poke(12'h220, 8'h31);
    poke(12'h221, 8'h42); poke(12'h222, 8'h30); poke(12'h223, 8'h02);
    poke(12'h224, 8'h10); poke(12'h225, 8'hEE);
    poke(12'h226, 8'h15); poke(12'h227, 8'h13); poke(12'h228, 8'h03);
    poke(12'h229, 8'h40); poke(12'h22A, 8'h29); poke(12'h22B, 8'h02);
    poke(12'h230, 8'h10); poke(12'h231, 8'h5A);
    poke(12'h232, 8'h15); poke(12'h233, 8'h13); poke(12'h234, 8'h03);
    poke(12'h235, 8'h41); poke(12'h236, 8'h50); poke(12'h237, 8'h02);
    poke(12'h238, 8'h18); poke(12'h239, 8'hFF);
    poke(12'h23A, 8'h34);
    poke(12'h23B, 8'h1D); poke(12'h23C, 8'h14); poke(12'h23D, 8'h03);
    poke(12'h23E, 8'h40); poke(12'h23F, 8'h3E); poke(12'h240, 8'h02);
    poke(12'h240, 8'h34);
    poke(12'h241, 8'h1D); poke(12'h242, 8'h20); poke(12'h243, 8'h03);
    poke(12'h244, 8'h44);
    poke(12'h250, 8'h10); poke(12'h251, 8'hBB);
    poke(12'h252, 8'h15); poke(12'h253, 8'h13); poke(12'h254, 8'h03);
    poke(12'h255, 8'h40); poke(12'h256, 8'h55); poke(12'h257, 8'h02);
    run();
    check("R4 STA abs,X",      {8'h00, mem[12'h302]}, 16'h00A5);
    check("R2 LDA abs,X",      {8'h00, mem[12'h310]}, 16'h00A5);
    check("R9 PHX slot",       {8'h00, mem[12'h1FE]}, 16'h0001);
    check("R9 PHA reuse slot", {8'h00, mem[12'h1FF]}, 16'h0000);
    check("R12 ret high",      {8'h00, mem[12'h1FD]}, 16'h0002);
    check("R12 ret low",       {8'h00, mem[12'h1FC]}, 16'h0013);
    check("R12 subroutine X",  {8'h00, mem[12'h320]}, 16'h0002);
    check("R10 PLA value",     {8'h00, mem[12'h311]}, 16'h0001);
    check("R10 PLX value",     {8'h00, mem[12'h312]}, 16'h00A5);
    check("R11 BZ taken BCS not", {8'h00, mem[12'h313]}, 16'h005A);
    check("R8 INX wrap",       {8'h00, mem[12'h314]}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R1 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule